// File: doc/BRIEF.md
# Programmable Waveform Sample Sequencer

This block replays a stored waveform towards a DAC sample interface. Samples live in an internal table of 1024 words of 16 bits that can be rewritten at any time through a simple write port. Playback walks a programmable number of entries, always starting at entry 0. It runs either a single pass or loops until it is stopped. Each sample is presented together with a one-cycle valid strobe.

The spacing between samples is the product of two programmable values. The first is a clock divider with a floor of 32 cycles. The second is a rate multiplier that counts divided ticks. Configuration writes arrive as single-cycle strobes. The block keeps the live register values and the values used by the running playback separately. A change made during playback therefore only takes hold at the next sample boundary, and an interval already under way keeps its full length.

Top module: `wave_seq`

## Requirements
- R1: After reset `active`, `smp_valid` and `smp_data` are 0. The length register resets to 1024, the divider to 32 and the rate to 1.
- R2: A table write at address A with data D makes D the value presented when entry A is next played.
- R3: A length write with a value from 1 to 1024 is stored. A value of 0 or above 1024 leaves the previous length unchanged.
- R4: A divider write below 32 is stored as 32. A rate write of 0 is stored as 1.
- R5: The first strobe follows the start edge by exactly divider×rate cycles, and later strobes are spaced by divider×rate cycles.
- R6: When `mode_loop`=0 (single pass), entries 0 to length−1 are played once each. `active` falls on the same edge that raises the final strobe, and no strobe follows.
- R7: When `mode_loop`=1 (looped), the entry after length−1 is entry 0, and playback continues until it is stopped.
- R8: `smp_valid` is high for exactly one cycle per sample. `smp_data` changes only on an edge that raises `smp_valid`.
- R9: A `stop` pulse clears `active` on the next edge, and no further strobe is issued. If `start` and `stop` are both high, `stop` wins.
- R10: A `start` pulse during playback restarts at entry 0 with a fresh full interval.
- R11: Length, divider, rate and mode changes made during playback are applied from the next sample boundary onwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-domain clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_len_we | input | 1 | Length register write strobe |
| cfg_len_wdata | input | ADDR_W+1 | Requested playback length |
| cfg_div_we | input | 1 | Divider register write strobe |
| cfg_div_wdata | input | DIV_W | Requested clock divider |
| cfg_rate_we | input | 1 | Rate register write strobe |
| cfg_rate_wdata | input | RATE_W | Requested rate multiplier |
| tbl_we | input | 1 | Sample table write enable |
| tbl_waddr | input | ADDR_W | Sample table write address |
| tbl_wdata | input | DATA_W | Sample table write data |
| mode_loop | input | 1 | 1 = looped playback, 0 = single pass |
| start | input | 1 | Begin or restart playback |
| stop | input | 1 | End playback |
| smp_data | output | DATA_W | Current sample |
| smp_valid | output | 1 | One-cycle strobe for each new sample |
| active | output | 1 | Playback in progress |

## Verification
The bench first loads the whole table with a hashed pattern. It then runs a full-length single pass at the default settings, which separates a correct end-of-table stop from address wrap faults. Short single passes with clamped and rejected register writes show whether illegal values are filtered or taken as written. A looped run then receives a mid-interval rate change and a mode change, which shows whether updates wait for the next boundary. Stop, a simultaneous start and stop, a restart during playback and a length of one probe the control priorities and the shortest pass.

// File: rtl/wave_seq_pkg.sv
// Shared definitions for the waveform sample sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package wave_seq_pkg;

    // Playback mode as sampled from mode_loop.
    typedef enum logic {
        PLAY_ONCE = 1'b0,
        PLAY_LOOP = 1'b1
    } play_mode_e;

    // Smallest legal clock divider.
    localparam int unsigned DIV_FLOOR = 32;

endpackage

// File: rtl/wave_seq_cfg.sv
// Live configuration registers: playback length, divider, rate.
// Filters every write: out-of-range lengths are dropped, small
// dividers are raised to the floor, and a zero rate becomes one.
// Assumes: DIV_W is wide enough to hold DIV_MIN.
module wave_seq_cfg #(
    parameter int unsigned ADDR_W  = 10,
    parameter int unsigned DIV_W   = 16,
    parameter int unsigned RATE_W  = 16,
    parameter int unsigned DIV_MIN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              len_we,
    input  logic [ADDR_W:0]   len_wdata,
    input  logic              div_we,
    input  logic [DIV_W-1:0]  div_wdata,
    input  logic              rate_we,
    input  logic [RATE_W-1:0] rate_wdata,
    output logic [ADDR_W:0]   len_q,
    output logic [DIV_W-1:0]  div_q,
    output logic [RATE_W-1:0] rate_q
);
    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W:0]   LEN_MAX = (ADDR_W+1)'(DEPTH);
    localparam logic [DIV_W-1:0]  DIV_LO  = DIV_W'(DIV_MIN);

    logic len_ok;
    assign len_ok = (len_wdata != '0) && (len_wdata <= LEN_MAX);

    // Register update with range filtering on each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q  <= LEN_MAX;
            div_q  <= DIV_LO;
            rate_q <= RATE_W'(1);
        end else begin
            if (len_we && len_ok) len_q <= len_wdata;
            if (div_we)  div_q  <= (div_wdata < DIV_LO) ? DIV_LO : div_wdata;
            if (rate_we) rate_q <= (rate_wdata == '0) ? RATE_W'(1) : rate_wdata;
        end
    end

    assert_len_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (len_q != '0) && (len_q <= LEN_MAX));
    assert_div_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        div_q >= DIV_LO);
    assert_rate_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rate_q != '0);

endmodule

// File: rtl/wave_seq_pacer.sv
// Interval timer: a divider counter feeding a rate counter. Raises
// boundary in the last cycle of each divider x rate cycle window.
// Assumes: lim_div >= 1 and lim_rate >= 1; limits only change in the
// cycle after a boundary or a restart, when both counters are zero.
module wave_seq_pacer #(
    parameter int unsigned DIV_W  = 16,
    parameter int unsigned RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              run,
    input  logic [DIV_W-1:0]  lim_div,
    input  logic [RATE_W-1:0] lim_rate,
    output logic              boundary
);
    logic [DIV_W-1:0]  div_cnt;
    logic [RATE_W-1:0] rate_cnt;
    logic              div_end, rate_end;

    assign div_end  = (div_cnt  == lim_div  - DIV_W'(1));
    assign rate_end = (rate_cnt == lim_rate - RATE_W'(1));
    assign boundary = run && !restart && div_end && rate_end;

    // Advance the two cascaded counters while playback runs.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) begin
            div_cnt  <= '0;
            rate_cnt <= '0;
        end else if (div_end) begin
            div_cnt  <= '0;
            rate_cnt <= rate_end ? '0 : rate_cnt + RATE_W'(1);
        end else begin
            div_cnt  <= div_cnt + DIV_W'(1);
        end
    end

    assert_div_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (div_cnt < lim_div) && (rate_cnt < lim_rate));
    assert_rate_steps_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart && !div_end) |=> $stable(rate_cnt));

endmodule

// File: rtl/wave_seq_table.sv
// Sample table: synchronous write, combinational read.
// Assumes: contents are undefined until written.
module wave_seq_table #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store one word per enabled cycle.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/wave_seq.sv
// Waveform sample sequencer top. Keeps the playback state (address,
// active flag, and the settings captured for the current interval),
// and issues one strobed sample at each interval boundary.
// Assumes: configuration and table inputs are synchronous to clk.
module wave_seq
    import wave_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DIV_W  = 16,
    parameter int unsigned RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_len_we,
    input  logic [ADDR_W:0]   cfg_len_wdata,
    input  logic              cfg_div_we,
    input  logic [DIV_W-1:0]  cfg_div_wdata,
    input  logic              cfg_rate_we,
    input  logic [RATE_W-1:0] cfg_rate_wdata,
    input  logic              tbl_we,
    input  logic [ADDR_W-1:0] tbl_waddr,
    input  logic [DATA_W-1:0] tbl_wdata,
    input  logic              mode_loop,
    input  logic              start,
    input  logic              stop,
    output logic [DATA_W-1:0] smp_data,
    output logic              smp_valid,
    output logic              active
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [ADDR_W:0]   len_q;
    logic [DIV_W-1:0]  div_q;
    logic [RATE_W-1:0] rate_q;
    logic [ADDR_W:0]   run_len;
    logic [DIV_W-1:0]  run_div;
    logic [RATE_W-1:0] run_rate;
    play_mode_e        run_mode;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] rd_word;
    logic              boundary, go, at_last;

    assign go      = start && !stop;
    assign at_last = ({1'b0, addr_q} >= run_len - (ADDR_W+1)'(1));

    wave_seq_cfg #(
        .ADDR_W(ADDR_W), .DIV_W(DIV_W), .RATE_W(RATE_W), .DIV_MIN(DIV_FLOOR)
    ) i_cfg (
        .clk(clk), .rst_n(rst_n),
        .len_we(cfg_len_we), .len_wdata(cfg_len_wdata),
        .div_we(cfg_div_we), .div_wdata(cfg_div_wdata),
        .rate_we(cfg_rate_we), .rate_wdata(cfg_rate_wdata),
        .len_q(len_q), .div_q(div_q), .rate_q(rate_q)
    );

    wave_seq_pacer #(.DIV_W(DIV_W), .RATE_W(RATE_W)) i_pacer (
        .clk(clk), .rst_n(rst_n), .restart(go), .run(active),
        .lim_div(run_div), .lim_rate(run_rate), .boundary(boundary)
    );

    wave_seq_table #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_table (
        .clk(clk), .we(tbl_we), .waddr(tbl_waddr), .wdata(tbl_wdata),
        .raddr(addr_q), .rdata(rd_word)
    );

    // Playback control: stop beats start, start beats a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            addr_q    <= '0;
            smp_valid <= 1'b0;
            smp_data  <= '0;
            run_len   <= (ADDR_W+1)'(DEPTH);
            run_div   <= DIV_W'(DIV_FLOOR);
            run_rate  <= RATE_W'(1);
            run_mode  <= PLAY_ONCE;
        end else begin
            smp_valid <= 1'b0;
            if (stop) begin
                active <= 1'b0;
            end else if (start) begin
                active   <= 1'b1;
                addr_q   <= '0;
                run_len  <= len_q;
                run_div  <= div_q;
                run_rate <= rate_q;
                run_mode <= play_mode_e'(mode_loop);
            end else if (boundary) begin
                smp_valid <= 1'b1;
                smp_data  <= rd_word;
                if (!at_last)                  addr_q <= addr_q + ADDR_W'(1);
                else if (run_mode == PLAY_LOOP) addr_q <= '0;
                else                           active <= 1'b0;
                run_len  <= len_q;
                run_div  <= div_q;
                run_rate <= rate_q;
                run_mode <= play_mode_e'(mode_loop);
            end
        end
    end

    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid);
    assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |-> $stable(smp_data));
    assert_strobe_from_play_R6: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> $past(active));
    assert_once_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && at_last && run_mode == PLAY_ONCE && !start && !stop)
        |=> (!active && smp_valid));
    assert_stop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!active && !smp_valid));
    assert_restart_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (active && addr_q == '0));

endmodule

// File: tb/test_wave_seq.sv
module test_wave_seq;
    localparam int AW = 10, DW = 16, PW = 16, SW = 16;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_len_we = 0, cfg_div_we = 0, cfg_rate_we = 0, tbl_we = 0;
    logic [AW:0] cfg_len_wdata = '0;
    logic [PW-1:0] cfg_div_wdata = '0;
    logic [SW-1:0] cfg_rate_wdata = '0;
    logic [AW-1:0] tbl_waddr = '0;
    logic [DW-1:0] tbl_wdata = '0;
    logic mode_loop = 0, start = 0, stop = 0;
    logic [DW-1:0] smp_data;
    logic smp_valid, active;

    always #4 clk = ~clk;

    wave_seq i_wave_seq (.*);

    int n_vec = 0, n_bad = 0, cyc = 0;
    int n_strobe = 0, first_cyc = -1, last_cyc = 0, gap = 0, st_cyc = 0;
    int last_data = 0, first_data = -1;
    bit finished = 0;

    // reference model state
    int m_len, m_div, m_rate, e_len, e_div, e_rate, e_loop;
    int m_act, m_addr, m_el, m_val, m_dat;
    int mem [DEPTH];

    function automatic int pat(int i);
        return (i * 40503 + 17) & 16'hFFFF;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Model step and per-cycle comparison.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_len = DEPTH; m_div = 32; m_rate = 1;
            e_len = DEPTH; e_div = 32; e_rate = 1; e_loop = 0;
            m_act = 0; m_addr = 0; m_el = 0; m_val = 0; m_dat = 0;
        end else begin
            m_val = 0;
            if (stop) m_act = 0;
            else if (start) begin
                m_act = 1; m_addr = 0; m_el = 0;
                e_len = m_len; e_div = m_div; e_rate = m_rate; e_loop = mode_loop;
            end else if (m_act != 0) begin
                m_el++;
                if (m_el == e_div * e_rate) begin
                    m_el = 0; m_val = 1; m_dat = mem[m_addr];
                    if (m_addr >= e_len - 1) begin
                        if (e_loop != 0) m_addr = 0; else m_act = 0;
                    end else m_addr++;
                    e_len = m_len; e_div = m_div; e_rate = m_rate; e_loop = mode_loop;
                end
            end
            if (cfg_len_we && cfg_len_wdata >= 1 && cfg_len_wdata <= DEPTH) m_len = cfg_len_wdata;
            if (cfg_div_we) m_div = (cfg_div_wdata < 32) ? 32 : int'(cfg_div_wdata);
            if (cfg_rate_we) m_rate = (cfg_rate_wdata == 0) ? 1 : int'(cfg_rate_wdata);
            if (tbl_we) mem[tbl_waddr] = tbl_wdata;
        end
        #1;
        if (rst_n && !finished) begin
            n_vec++;
            if (smp_valid !== m_val[0] || active !== m_act[0] ||
                (m_val != 0 && smp_data !== m_dat[DW-1:0])) begin
                n_bad++;
                $display("FAIL R5/R6/R2 cycle %0d: actual v=%0b a=%0b d=%0h expected v=%0d a=%0d d=%0h",
                         cyc, smp_valid, active, smp_data, m_val, m_act, m_dat);
            end
            if (smp_valid) begin
                if (n_strobe == 0) begin first_cyc = cyc; first_data = smp_data; end
                gap = cyc - last_cyc; last_cyc = cyc;
                last_data = smp_data; n_strobe++;
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic wr_len(int v);
        @(negedge clk); cfg_len_we = 1; cfg_len_wdata = (AW+1)'(v);
        @(negedge clk); cfg_len_we = 0;
    endtask
    task automatic wr_div(int v);
        @(negedge clk); cfg_div_we = 1; cfg_div_wdata = PW'(v);
        @(negedge clk); cfg_div_we = 0;
    endtask
    task automatic wr_rate(int v);
        @(negedge clk); cfg_rate_we = 1; cfg_rate_wdata = SW'(v);
        @(negedge clk); cfg_rate_we = 0;
    endtask
    task automatic go(int loop_mode);
        @(negedge clk); mode_loop = loop_mode[0]; start = 1; st_cyc = cyc + 1;
        n_strobe = 0; first_cyc = -1;
        @(negedge clk); start = 0;
    endtask
    task automatic halt();
        @(negedge clk); stop = 1;
        @(negedge clk); stop = 0;
    endtask

    initial begin
        #(8 * 190000);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1;
        idle(1);
        // R1: reset state at the ports
        chk("R1 active", active, 0);
        chk("R1 valid", smp_valid, 0);
        chk("R1 data", smp_data, 0);

        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk); tbl_we = 1; tbl_waddr = AW'(i); tbl_wdata = DW'(pat(i));
        end
        @(negedge clk); tbl_we = 0;

        // R1/R5/R6: full default pass (1024 samples, interval 32)
        go(0);
        idle(DEPTH * 32 + 20);
        chk("R1 default length", n_strobe, DEPTH);
        chk("R5 default gap", gap, 32);
        chk("R6 last entry", last_data, pat(DEPTH - 1));
        chk("R6 inactive after pass", active, 0);

        // R5/R6: short pass, interval 64
        wr_len(4); wr_div(32); wr_rate(2);
        go(0);
        idle(4 * 64 + 40);
        chk("R5 first delay", first_cyc - st_cyc, 64);
        chk("R5 gap", gap, 64);
        chk("R6 strobe count", n_strobe, 4);

        // R3/R4: filtered writes
        wr_div(5); wr_rate(0); wr_len(0); wr_len(2000);
        go(0);
        idle(4 * 32 + 40);
        chk("R3 rejected length kept", n_strobe, 4);
        chk("R4 divider floor and rate one", gap, 32);

        // R2: rewrite of one entry
        @(negedge clk); tbl_we = 1; tbl_waddr = 2; tbl_wdata = 16'hBEEF;
        @(negedge clk); tbl_we = 0;
        wr_len(3);
        go(0);
        idle(3 * 32 + 20);
        chk("R2 rewritten entry", last_data, 16'hBEEF);

        // R7/R11: looped playback, rate change mid interval
        wr_div(40); wr_rate(1);
        go(1);
        idle(7 * 40 + 10);
        chk("R7 wraps past length", n_strobe, 7);
        chk("R7 still active", active, 1);
        wr_rate(3);
        idle(300);
        chk("R11 new interval", gap, 120);
        @(negedge clk); mode_loop = 0;
        idle(3 * 120 + 130);
        chk("R11 mode change ends loop", active, 0);

        // R9: stop, and start with stop together
        go(1);
        idle(100);
        halt();
        begin
            int held = n_strobe;
            idle(200);
            chk("R9 no strobe after stop", n_strobe, held);
        end
        chk("R9 inactive", active, 0);
        @(negedge clk); start = 1; stop = 1;
        @(negedge clk); start = 0; stop = 0;
        idle(2);
        chk("R9 stop wins", active, 0);

        // R10: restart during playback
        wr_div(32); wr_rate(2); wr_len(5);
        go(1);
        idle(150);
        go(1);
        idle(70);
        chk("R10 fresh interval", first_cyc - st_cyc, 64);
        chk("R10 from entry 0", first_data, pat(0));
        halt();

        // R6: length of one
        wr_len(1);
        go(0);
        idle(200);
        chk("R6 single sample", n_strobe, 1);
        chk("R8 one strobe width", smp_valid, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule